// File: doc/BRIEF.md
# Status-Read Serial Slave

This block is a two-wire serial bus slave that only answers reads. It watches the open-drain clock and data lines, oversampled by a local clock, and drives the data line through a single pull-low enable. When a START is followed by its own address with the direction bit set to read, it acknowledges. It then shifts out a status byte, most significant bit first.

The status byte carries a sticky power-on flag, a loop-lock flag, an AGC-active flag and a 3-bit converter code. Those values arrive as plain inputs. The block keeps sending fresh copies of the status for as long as the master acknowledges each byte. A byte left unacknowledged ends the read, releases the line and clears the power-on flag.

Two address bits come from strap inputs, so several slaves can share one bus.

Top module: `i2c_status_slave`

## Requirements
- R1: The address byte is received MSB first. Its bits 7..3 must equal 11000, bits 2..1 must equal addr_sel_i[1:0], and bit 0 (R/W) must be 1. On a match, sda_pull_o is asserted for the whole ninth (acknowledge) clock.
- R2: If the address does not match, or R/W is 0, the slave gives no acknowledge. It keeps sda_pull_o low until the next START.
- R3: Each status byte has bit 7 = power-on flag, bit 6 = lock, bits 5 and 4 = 1, bit 3 = AGC, and bits 2..0 = the converter code. The byte is sent MSB first, and sda_pull_o is high exactly for the 0 bits.
- R4: sda_pull_o changes only while SCL is low. It is never changed during an SCL high phase.
- R5: Each time the master acknowledges a byte (SDA low on the ninth clock), another byte follows. Every byte carries the lock, AGC and code values present at the start of the acknowledge slot that precedes it.
- R6: When the master does not acknowledge (SDA high on the ninth clock), the transfer ends, sda_pull_o is released and stays released until the next START.
- R7: The power-on flag is 1 after reset. It is cleared only by a master non-acknowledge that ends a read. A mismatched address, a write-direction address and an aborted transfer all leave it unchanged, and it is never set again without reset.
- R8: A STOP during a transfer returns the slave to idle with SDA released. A START during a transfer begins a new address phase.
- R9: After reset the slave is idle and sda_pull_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Strap bits for the two programmable address bits |
| lock_i | input | 1 | Loop-lock flag |
| agc_i | input | 1 | AGC-active flag |
| adc_code_i | input | 3 | Converter code |

## Verification
The hardest situation to reach is a START or STOP in the middle of a data byte. While the slave drives a 0, the master cannot move SDA at all. The bench therefore reads the first two status bits, which are both 1, so the slave has released SDA on the third bit. It then raises SCL and drops or raises SDA to make the bus condition. A following good read shows that the power-on flag survived the abort. Per-byte capture is exercised by changing the status inputs halfway through each byte of a four-byte read.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  localparam int STAT_W = 8;
  localparam int CODE_W = 3;
  localparam int SEL_W = 2;
  localparam int CNT_W = $clog2(STAT_W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STAT_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAT_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK
  } slv_state_e;
endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/stat_line_mon.sv
module stat_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // bus conditions: SDA moves while SCL held high
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
  import i2c_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI = 5'b11000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              lock_i,
  input  logic              agc_i,
  input  logic [CODE_W-1:0] adc_code_i
);
  localparam int IN_W = SEL_W + 2 + CODE_W;

  logic scl_h, sda_h;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [IN_W-1:0] in_s;
  logic [SEL_W-1:0] sel_s;
  logic lock_s, agc_s;
  logic [CODE_W-1:0] code_s;

  stat_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_h, sda_h})
  );

  stat_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_in_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_sel_i, lock_i, agc_i, adc_code_i}),
    .q_o   (in_s)
  );
  assign {sel_s, lock_s, agc_s, code_s} = in_s;

  stat_line_mon u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_h),
    .sda_s_i   (sda_h),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [STAT_W-1:0] rx_q, tx_q;
  logic              pull_q, por_q, mack_q;
  logic [STAT_W-1:0] status;
  logic              addr_hit;

  assign status   = {por_q, lock_s, 2'b11, agc_s, code_s};
  assign addr_hit = (rx_q[STAT_W-1:1] == {ADDR_HI, sel_s}) && rx_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      pull_q   <= 1'b0;
      por_q    <= 1'b1;
      mack_q   <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      pull_q   <= 1'b0;
      bitcnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && bitcnt_q != CNT_FULL) begin
            rx_q     <= {rx_q[STAT_W-2:0], sda_h};
            bitcnt_q <= bitcnt_q + CNT_ONE;
          end else if (scl_fall && bitcnt_q == CNT_FULL) begin
            if (addr_hit) begin
              state_q <= ST_AACK;
              pull_q  <= 1'b1;
              tx_q    <= status;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            state_q  <= ST_TX;
            pull_q   <= ~tx_q[STAT_W-1];
            bitcnt_q <= '0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == CNT_LAST) begin
              state_q <= ST_MACK;
              pull_q  <= 1'b0;
              tx_q    <= status;  // capture at start of ack slot
              mack_q  <= 1'b0;
            end else begin
              tx_q     <= {tx_q[STAT_W-2:0], 1'b0};
              pull_q   <= ~tx_q[STAT_W-2];
              bitcnt_q <= bitcnt_q + CNT_ONE;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_h) begin
              state_q <= ST_IDLE;
              por_q   <= 1'b0;
            end else begin
              mack_q <= 1'b1;
            end
          end else if (scl_fall && mack_q) begin
            state_q  <= ST_TX;
            pull_q   <= ~tx_q[STAT_W-1];
            bitcnt_q <= '0;
          end
        end
        default: pull_q <= 1'b0;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  // R4: no SDA movement during a stable SCL high phase
  p_sda_stable_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_h && $past(scl_h)) |-> $stable(pull_q));

  // R2, R6: idle never drives
  p_idle_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pull_q);

  // R1: acknowledge slot holds SDA low
  p_ack_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK) |-> pull_q);

  // R7: flag only falls out of the master-ack slot
  p_por_clear_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_q) |-> ($past(state_q) == ST_MACK));

  // R7: flag never sets again
  p_por_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_q |=> !por_q);

  // R8: STOP always idles
  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE));

  // R8: START always opens an address phase
  p_start_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !stop_det) |=> (state_q == ST_ADDR));
endmodule

// File: tb/i2c_status_slave_bench.sv
module i2c_status_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pull = 1'b0;
  logic sda;
  logic sda_pull;
  logic [1:0] sel = 2'b00;
  logic lock = 1'b0, agc = 1'b0;
  logic [2:0] code = 3'd0;

  int n_tests = 0, n_fail = 0;
  int pull_cnt = 0, viol = 0;
  logic prev_scl = 1'b1, prev_pull = 1'b0;
  logic addr_ack;
  logic [7:0] rx [4];
  logic pl [4];
  logic pa [4];
  logic [2:0] pc [4];

  always #2 clk = ~clk;
  assign sda = ~(m_pull | sda_pull);

  i2c_status_slave u_i2c_status_slave (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda),
    .sda_pull_o(sda_pull),
    .addr_sel_i(sel),
    .lock_i    (lock),
    .agc_i     (agc),
    .adc_code_i(code)
  );

  always @(negedge clk) begin
    if (sda_pull) pull_cnt++;
    if (rst_n && scl && prev_scl && sda_pull != prev_pull) viol++;
    prev_scl  <= scl;
    prev_pull <= sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic p, input logic l, input logic a, input logic [2:0] c);
    return {p, l, 2'b11, a, c};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; m_pull = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic set_in(input logic l, input logic a, input logic [2:0] c);
    lock = l; agc = a; code = c;
  endtask

  task automatic bus_start();
    m_pull = 1'b0; scl = 1'b1; tick(Q);
    m_pull = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_pull = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_pull = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_pull = ~b; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_pull = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    b = sda; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // address phase plus ack sample
  task automatic addr_phase(input logic [6:0] a7, input logic rw);
    logic b;
    send_byte({a7, rw});
    recv_bit(b);
    addr_ack = ~b;
  endtask

  task automatic read_bytes(input int n, input logic chg);
    logic b;
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        recv_bit(b);
        rx[k][i] = b;
        if (i == 4 && chg && k < 3) set_in(pl[k+1], pa[k+1], pc[k+1]);
      end
      send_bit(k == n - 1);
    end
  endtask

  task automatic xfer(input logic [6:0] a7, input logic rw, input int n, input logic chg);
    pull_cnt = 0;
    bus_start();
    addr_phase(a7, rw);
    read_bytes(n, chg);
    bus_stop();
    tick(2 * Q);
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 idle pull after reset", sda_pull, 1'b0);
  endtask

  task automatic t_single_read();
    do_reset();
    sel = 2'b10; set_in(1'b1, 1'b0, 3'd5);
    xfer(7'b1100010, 1'b1, 1, 1'b0);
    check("R1 address ack", addr_ack, 1'b1);
    check("R3 first status byte", rx[0], stat(1'b1, 1'b1, 1'b0, 3'd5));
    check("R6 released after nack", sda_pull, 1'b0);
    set_in(1'b0, 1'b1, 3'd2);
    xfer(7'b1100010, 1'b1, 1, 1'b0);
    check("R7 flag cleared by nack end", rx[0], stat(1'b0, 1'b0, 1'b1, 3'd2));
  endtask

  task automatic t_multi_read();
    do_reset();
    sel = 2'b01;
    pl[0] = 0; pa[0] = 1; pc[0] = 3'd2;
    pl[1] = 1; pa[1] = 0; pc[1] = 3'd7;
    pl[2] = 0; pa[2] = 0; pc[2] = 3'd0;
    pl[3] = 1; pa[3] = 1; pc[3] = 3'd3;
    set_in(pl[0], pa[0], pc[0]);
    xfer(7'b1100001, 1'b1, 4, 1'b1);
    check("R1 ack sel 01", addr_ack, 1'b1);
    for (int k = 0; k < 4; k++)
      check("R5 byte per ack slot", rx[k], stat(1'b1, pl[k], pa[k], pc[k]));
    xfer(7'b1100001, 1'b1, 1, 1'b0);
    check("R6 flag cleared after multi read", rx[0][7], 1'b0);
  endtask

  task automatic t_mismatch();
    do_reset();
    sel = 2'b00; set_in(1'b1, 1'b1, 3'd1);
    xfer(7'b1100011, 1'b1, 1, 1'b0);
    check("R2 no ack on mismatch", addr_ack, 1'b0);
    check("R2 data released", rx[0], 8'hFF);
    check("R2 never pulled", pull_cnt, 0);
    xfer(7'b1100000, 1'b1, 1, 1'b0);
    check("R7 flag survives mismatch", rx[0], stat(1'b1, 1'b1, 1'b1, 3'd1));
  endtask

  task automatic t_write_dir();
    do_reset();
    sel = 2'b11; set_in(1'b0, 1'b0, 3'd6);
    xfer(7'b1100011, 1'b0, 1, 1'b0);
    check("R2 no ack on write", addr_ack, 1'b0);
    check("R2 write never pulled", pull_cnt, 0);
    xfer(7'b1100011, 1'b1, 1, 1'b0);
    check("R7 flag survives write", rx[0], stat(1'b1, 1'b0, 1'b0, 3'd6));
  endtask

  task automatic t_abort_stop();
    logic b;
    do_reset();
    sel = 2'b00; set_in(1'b1, 1'b0, 3'd0);
    bus_start();
    addr_phase(7'b1100000, 1'b1);
    recv_bit(b); recv_bit(b);
    tick(Q);
    m_pull = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_pull = 1'b0; tick(Q);
    pull_cnt = 0;
    tick(8 * Q);
    check("R8 stop mid-byte releases", pull_cnt, 0);
    xfer(7'b1100000, 1'b1, 1, 1'b0);
    check("R7 flag survives stop abort", rx[0], stat(1'b1, 1'b1, 1'b0, 3'd0));
  endtask

  task automatic t_abort_start();
    logic b;
    do_reset();
    sel = 2'b10; set_in(1'b1, 1'b1, 3'd4);
    bus_start();
    addr_phase(7'b1100010, 1'b1);
    recv_bit(b); recv_bit(b);
    tick(Q);
    m_pull = 1'b0; scl = 1'b1; tick(Q);
    m_pull = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
    addr_phase(7'b1100010, 1'b1);
    check("R8 start mid-byte new address phase", addr_ack, 1'b1);
    read_bytes(1, 1'b0);
    bus_stop();
    tick(2 * Q);
    check("R7 flag survives start abort", rx[0], stat(1'b1, 1'b1, 1'b1, 3'd4));
  endtask

  initial begin
    t_reset();
    t_single_read();
    t_multi_read();
    t_mismatch();
    t_write_dir();
    t_abort_stop();
    t_abort_start();
    check("R4 no SDA change while SCL high", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule